// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the external bus timing for a small 8-bit controller core that shares one byte-wide port between the low address byte and the data. A machine cycle is twelve clock periods long and is split into two halves of six. Every half carries one slot. A slot is idle, an internal code fetch, an external code fetch, or one of the two halves of a data transfer. The address latch strobe pulses at the start of every half, so it can serve as a free-running timing output at one sixth of the clock rate. A data transfer always fills a whole machine cycle. Its first half places the address on the bus. Its second half runs the read or write strobe in the slot where the strobe pulse would have been, so that pulse is left out.

The core gives the block a code fetch request with a 16-bit address, and a data request with a 16-bit pointer address or an 8-bit register-indirect address. It also gives the level of the external-code pin and the current contents of the high-port register. Requests are levels. The core holds a request until the block acknowledges it in the first clock of the slot that serves it. The block decides whether each code fetch goes to the external bus or to the on-chip code store. It drives the strobes, the low port with its output enable, and the high port with a strong-drive flag. It samples the returned byte from the low port on the rising edge of the fetch or read strobe.

Top module: `ext_bus_sequencer`

## Requirements
- R1: `ale` is high for 2 clocks at sub-phases 0 and 1 of every half-cycle, so the spacing between rising edges is 6 clocks. The first clock after reset release is sub-phase 0 of a first half. The strobe keeps running during idle and fetch slots.
- R2: During each data transfer exactly one `ale` pulse is dropped: the one in the transfer (second) half. The machine cycle of a data access shows one pulse and a 12-clock gap between rising edges.
- R3: In the address phase of an external fetch or a data access (sub-phases 0 and 1), `lo_oe` is high and `lo_out` carries address bits 7:0. On a write, `lo_oe` stays high with the write byte on `lo_out` from sub-phase 2 of the address half to the end of the transfer half.
- R4: On a read, `lo_oe` is low through the transfer half. `rd_n` is low in sub-phases 1 to 4 of that half. `lo_in` is captured on the edge that ends sub-phase 4 and is shown on `data_rbyte` when `data_done` pulses in sub-phase 5.
- R5: For an external code fetch, and for a data access with `data_wide`=1, `hi_out` carries address bits 15:8 with `hi_strong` high for the whole slot (both halves for data).
- R6: For a data access with `data_wide`=0, and in idle or internal slots, `hi_out` equals `hi_port_reg` and `hi_strong` is low.
- R7: A code fetch goes external when `ext_code_n` is 0, or when the address is at or above INT_CODE_SIZE (default 4096). Otherwise it is internal. An internal fetch leaves `psen_n` high and the low port released, and pulses `fetch_done` with `fetch_external`=0.
- R8: `psen_n` is low only in sub-phases 2 to 4 of an external code slot. `lo_in` is captured on its rising edge and shown on `code_byte` when `fetch_done` pulses in sub-phase 5.
- R9: `rd_n` and `wr_n` go low only in sub-phases 1 to 4 of a transfer half: `wr_n` for writes (`data_write`=1) and `rd_n` for reads. No two of `psen_n`, `rd_n` and `wr_n` are ever low together.
- R10: A data request is taken only at the start of a machine cycle and takes priority over a pending fetch. A data request raised before a second half waits one idle half. `fetch_ack` or `data_ack` pulses in sub-phase 0 of the slot that serves the request.
- R11: When no external access is in progress, the low port sits at `lo_out`=8'hFF with `lo_oe` low, and all active-low strobes are high. During reset, `ale` is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per oscillator tick |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_code_n | input | 1 | 0 sends every code fetch to the external bus |
| hi_port_reg | input | 8 | Current contents of the high-port register |
| fetch_req | input | 1 | Code fetch request, held until acknowledged |
| fetch_addr | input | 16 | Code fetch address |
| fetch_ack | output | 1 | Fetch accepted, sub-phase 0 of its slot |
| fetch_done | output | 1 | Fetch slot finishing, sub-phase 5 |
| fetch_external | output | 1 | Current code slot uses the external bus |
| code_byte | output | 8 | Last byte captured by an external fetch |
| data_req | input | 1 | Data access request, held until acknowledged |
| data_write | input | 1 | 1 write, 0 read |
| data_wide | input | 1 | 1 pointer (16-bit) address, 0 register-indirect (8-bit) |
| data_addr | input | 16 | Data address (bits 15:8 unused when narrow) |
| data_wbyte | input | 8 | Write data |
| data_ack | output | 1 | Data access accepted |
| data_done | output | 1 | Data transfer finishing |
| data_rbyte | output | 8 | Last byte captured by a read |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low port output value |
| lo_oe | output | 1 | Low port output enable |
| lo_in | input | 8 | Low port pin value |
| hi_out | output | 8 | High port output value |
| hi_strong | output | 1 | High port strong drive while it carries address |

## Verification
The bench runs fetches over both levels of the external-code pin and over addresses on each side of the internal code limit. It also runs every combination of read or write with wide or narrow addressing, sometimes starting on a second half so the request has to wait. A design that forgot to drop the transfer-half strobe pulse, or dropped one too many, would show the wrong gap count. A design that sourced the high port from the address on narrow accesses would show address bits where the register value belongs. The returned byte on `lo_in` is valid only in the clock before the strobe rises, so a design that samples one clock early or late captures its inverse. A simultaneous fetch and data request shows whether the data access wins.

// File: rtl/ebs_pkg.sv
// Package: shared slot encoding for the external bus sequencer.
// Assumes one slot per half machine cycle.
package ebs_pkg;

    typedef enum logic [2:0] {
        SLOT_IDLE      = 3'd0,
        SLOT_CODE_INT  = 3'd1,
        SLOT_CODE_EXT  = 3'd2,
        SLOT_DATA_ADDR = 3'd3,
        SLOT_DATA_XFER = 3'd4
    } slot_kind_e;

    // True for both code slot kinds.
    function automatic logic is_code(input slot_kind_e k);
        return (k == SLOT_CODE_INT) || (k == SLOT_CODE_EXT);
    endfunction

    // True for both halves of a data transfer.
    function automatic logic is_data(input slot_kind_e k);
        return (k == SLOT_DATA_ADDR) || (k == SLOT_DATA_XFER);
    endfunction

endpackage

// File: rtl/ebs_phase_gen.sv
// Phase generator: counts clocks in a machine cycle of CYCLE_LEN clocks and
// derives the sub-phase within the current half.
// Assumes CYCLE_LEN is even and each half has at least 4 clocks.
// Reset parks the counter on the last clock so the first clock after
// reset release is sub-phase 0 of a first half.
module ebs_phase_gen #(
    parameter int CYCLE_LEN = 12,
    localparam int HALF  = CYCLE_LEN / 2,
    localparam int PH_W  = $clog2(CYCLE_LEN),
    localparam int SUB_W = $clog2(HALF)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SUB_W-1:0] sub,
    output logic             second_half,
    output logic             last_sub,
    output logic             cap_sub
);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CYCLE_LEN - 1);
    localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(HALF);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(HALF - 1);
    localparam logic [SUB_W-1:0] SUB_CAP  = SUB_W'(HALF - 2);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] sub_full;

    // Free-running cycle counter, wraps after the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph <= PH_LAST;
        else if (ph == PH_LAST)
            ph <= '0;
        else
            ph <= ph + 1'b1;
    end

    // Fold the cycle position into half and sub-phase.
    always_comb begin
        second_half = (ph >= PH_HALF);
        sub_full    = second_half ? (ph - PH_HALF) : ph;
        sub         = sub_full[SUB_W-1:0];
        last_sub    = (sub == SUB_LAST);
        cap_sub     = (sub == SUB_CAP);
    end

endmodule

// File: rtl/ebs_slot_sched.sv
// Slot scheduler: at the last clock of every half it picks the next slot
// and latches the request that the slot serves.
// Data accesses start only in a first half and take priority over fetches.
// A first data half is always followed by its transfer half.
// Assumes requests are held stable until acknowledged.
module ebs_slot_sched
    import ebs_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int INT_CODE_SIZE = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_sub,
    input  logic              second_half,
    input  logic              ext_code_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_req,
    input  logic              data_write,
    input  logic              data_wide,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wbyte,
    output slot_kind_e        slot,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_we,
    output logic              cur_wide,
    output logic [DATA_W-1:0] cur_wdata
);
    localparam logic [ADDR_W:0] INT_LIMIT = (ADDR_W + 1)'(INT_CODE_SIZE);

    logic fetch_goes_ext;

    // External decision for the fetch currently requested.
    always_comb begin
        fetch_goes_ext = !ext_code_n || ({1'b0, fetch_addr} >= INT_LIMIT);
    end

    // Choose and latch the next slot at each half boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot      <= SLOT_IDLE;
            cur_addr  <= '0;
            cur_we    <= 1'b0;
            cur_wide  <= 1'b0;
            cur_wdata <= '0;
        end else if (last_sub) begin
            if (slot == SLOT_DATA_ADDR) begin
                slot <= SLOT_DATA_XFER;
            end else if (second_half && data_req) begin
                slot      <= SLOT_DATA_ADDR;
                cur_addr  <= data_addr;
                cur_we    <= data_write;
                cur_wide  <= data_wide;
                cur_wdata <= data_wbyte;
            end else if (fetch_req) begin
                slot      <= fetch_goes_ext ? SLOT_CODE_EXT : SLOT_CODE_INT;
                cur_addr  <= fetch_addr;
                cur_we    <= 1'b0;
                cur_wide  <= 1'b1;
            end else begin
                slot <= SLOT_IDLE;
            end
        end
    end

endmodule

// File: rtl/ebs_pin_drive.sv
// Pin driver: decodes the strobes and port values from the current slot and
// sub-phase, and captures returned bytes at the strobe's rising edge.
// Assumes ALE_LEN + 2 <= HALF. The outputs are decoded from registers only.
module ebs_pin_drive
    import ebs_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int HALF    = 6,
    parameter int ALE_LEN = 2,
    localparam int SUB_W  = $clog2(HALF),
    localparam int HI_W   = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_kind_e        slot,
    input  logic [SUB_W-1:0]  sub,
    input  logic              last_sub,
    input  logic              cap_sub,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_we,
    input  logic              cur_wide,
    input  logic [DATA_W-1:0] cur_wdata,
    input  logic [HI_W-1:0]   hi_port_reg,
    input  logic [DATA_W-1:0] lo_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] lo_out,
    output logic              lo_oe,
    output logic [HI_W-1:0]   hi_out,
    output logic              hi_strong,
    output logic              fetch_ack,
    output logic              fetch_done,
    output logic              fetch_external,
    output logic              data_ack,
    output logic              data_done,
    output logic [DATA_W-1:0] code_byte,
    output logic [DATA_W-1:0] data_rbyte
);
    localparam logic [SUB_W-1:0] SUB_ALE_END = SUB_W'(ALE_LEN);
    localparam logic [SUB_W-1:0] SUB_STB_ON  = SUB_W'(1);
    localparam logic [SUB_W-1:0] SUB_CAP     = SUB_W'(HALF - 2);

    logic addr_phase;
    logic strobe_win;
    logic bus_addr_slot;
    logic hi_from_addr;

    // Sub-phase windows shared by several outputs.
    always_comb begin
        addr_phase    = (sub < SUB_ALE_END);
        strobe_win    = (sub >= SUB_STB_ON) && (sub <= SUB_CAP);
        bus_addr_slot = (slot == SLOT_CODE_EXT) || (slot == SLOT_DATA_ADDR);
        hi_from_addr  = (slot == SLOT_CODE_EXT) || (is_data(slot) && cur_wide);
    end

    // Strobe decode; the transfer half has no address strobe.
    always_comb begin
        ale    = addr_phase && (slot != SLOT_DATA_XFER);
        psen_n = !((slot == SLOT_CODE_EXT) && !addr_phase && (sub <= SUB_CAP));
        rd_n   = !((slot == SLOT_DATA_XFER) && !cur_we && strobe_win);
        wr_n   = !((slot == SLOT_DATA_XFER) && cur_we && strobe_win);
    end

    // Low port: address, then write data, else released and idling high.
    always_comb begin
        lo_out = '1;
        lo_oe  = 1'b0;
        if (bus_addr_slot && addr_phase) begin
            lo_out = cur_addr[DATA_W-1:0];
            lo_oe  = 1'b1;
        end else if (is_data(slot) && cur_we) begin
            lo_out = cur_wdata;
            lo_oe  = 1'b1;
        end
    end

    // High port: upper address with strong drive, or the port register.
    always_comb begin
        hi_out    = hi_from_addr ? cur_addr[ADDR_W-1:DATA_W] : hi_port_reg;
        hi_strong = hi_from_addr;
    end

    // Handshake pulses toward the core.
    always_comb begin
        fetch_ack      = is_code(slot) && (sub == '0);
        data_ack       = (slot == SLOT_DATA_ADDR) && (sub == '0);
        fetch_done     = is_code(slot) && last_sub;
        data_done      = (slot == SLOT_DATA_XFER) && last_sub;
        fetch_external = (slot == SLOT_CODE_EXT);
    end

    // Capture the returned byte on the edge where the read strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_byte  <= '0;
            data_rbyte <= '0;
        end else if (cap_sub) begin
            if (slot == SLOT_CODE_EXT)
                code_byte <= lo_in;
            if ((slot == SLOT_DATA_XFER) && !cur_we)
                data_rbyte <= lo_in;
        end
    end

endmodule

// File: rtl/ext_bus_sequencer.sv
// Top: multiplexed external bus sequencer. It ties the phase generator,
// the slot scheduler and the pin driver together.
// Assumes the core holds each request level until its acknowledge.
module ext_bus_sequencer
    import ebs_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int CYCLE_LEN     = 12,
    parameter int ALE_LEN       = 2,
    parameter int INT_CODE_SIZE = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_code_n,
    input  logic [ADDR_W-DATA_W-1:0] hi_port_reg,
    input  logic                 fetch_req,
    input  logic [ADDR_W-1:0]    fetch_addr,
    output logic                 fetch_ack,
    output logic                 fetch_done,
    output logic                 fetch_external,
    output logic [DATA_W-1:0]    code_byte,
    input  logic                 data_req,
    input  logic                 data_write,
    input  logic                 data_wide,
    input  logic [ADDR_W-1:0]    data_addr,
    input  logic [DATA_W-1:0]    data_wbyte,
    output logic                 data_ack,
    output logic                 data_done,
    output logic [DATA_W-1:0]    data_rbyte,
    output logic                 ale,
    output logic                 psen_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic [DATA_W-1:0]    lo_out,
    output logic                 lo_oe,
    input  logic [DATA_W-1:0]    lo_in,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic                 hi_strong
);
    localparam int HALF  = CYCLE_LEN / 2;
    localparam int SUB_W = $clog2(HALF);

    logic [SUB_W-1:0]  sub;
    logic              second_half;
    logic              last_sub;
    logic              cap_sub;
    slot_kind_e        slot;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_we;
    logic              cur_wide;
    logic [DATA_W-1:0] cur_wdata;

    ebs_phase_gen #(.CYCLE_LEN(CYCLE_LEN)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .sub         (sub),
        .second_half (second_half),
        .last_sub    (last_sub),
        .cap_sub     (cap_sub)
    );

    ebs_slot_sched #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .INT_CODE_SIZE (INT_CODE_SIZE)
    ) u_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .last_sub    (last_sub),
        .second_half (second_half),
        .ext_code_n  (ext_code_n),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .data_req    (data_req),
        .data_write  (data_write),
        .data_wide   (data_wide),
        .data_addr   (data_addr),
        .data_wbyte  (data_wbyte),
        .slot        (slot),
        .cur_addr    (cur_addr),
        .cur_we      (cur_we),
        .cur_wide    (cur_wide),
        .cur_wdata   (cur_wdata)
    );

    ebs_pin_drive #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .HALF    (HALF),
        .ALE_LEN (ALE_LEN)
    ) u_pins (
        .clk            (clk),
        .rst_n          (rst_n),
        .slot           (slot),
        .sub            (sub),
        .last_sub       (last_sub),
        .cap_sub        (cap_sub),
        .cur_addr       (cur_addr),
        .cur_we         (cur_we),
        .cur_wide       (cur_wide),
        .cur_wdata      (cur_wdata),
        .hi_port_reg    (hi_port_reg),
        .lo_in          (lo_in),
        .ale            (ale),
        .psen_n         (psen_n),
        .rd_n           (rd_n),
        .wr_n           (wr_n),
        .lo_out         (lo_out),
        .lo_oe          (lo_oe),
        .hi_out         (hi_out),
        .hi_strong      (hi_strong),
        .fetch_ack      (fetch_ack),
        .fetch_done     (fetch_done),
        .fetch_external (fetch_external),
        .data_ack       (data_ack),
        .data_done      (data_done),
        .code_byte      (code_byte),
        .data_rbyte     (data_rbyte)
    );

endmodule

// File: rtl/ebs_checker.sv
// Checker: temporal properties on the sequencer's ports, bound to the top.
// Measures the strobe spacing with its own counter.
module ebs_checker #(
    parameter int CYCLE_LEN = 12
) (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic lo_oe,
    input logic hi_strong,
    input logic fetch_ack,
    input logic data_ack,
    input logic fetch_done,
    input logic fetch_external
);
    localparam int HALF = CYCLE_LEN / 2;

    logic       ale_q;
    logic       seen_rise;
    logic [7:0] gap;

    // Track clocks between rising edges of the address strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q     <= 1'b0;
            seen_rise <= 1'b0;
            gap       <= '0;
        end else begin
            ale_q <= ale;
            if (ale && !ale_q) begin
                seen_rise <= 1'b1;
                gap       <= 8'd1;
            end else if (gap != 8'hFF) begin
                gap <= gap + 8'd1;
            end
        end
    end

    assert_ale_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !ale_q && seen_rise) |-> (gap == 8'(HALF) || gap == 8'(CYCLE_LEN)));

    assert_ale_skipped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !ale);

    assert_write_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> lo_oe);

    assert_read_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !lo_oe);

    assert_fetch_strong_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> hi_strong);

    assert_internal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_done && !fetch_external) |-> (psen_n && !lo_oe));

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!psen_n, !rd_n, !wr_n}));

    assert_single_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_ack, data_ack}));

    assert_strobe_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && !ale_q && seen_rise) |=> ale);

endmodule

bind ext_bus_sequencer ebs_checker #(.CYCLE_LEN(CYCLE_LEN)) u_ebs_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .ale            (ale),
    .psen_n         (psen_n),
    .rd_n           (rd_n),
    .wr_n           (wr_n),
    .lo_oe          (lo_oe),
    .hi_strong      (hi_strong),
    .fetch_ack      (fetch_ack),
    .data_ack       (data_ack),
    .fetch_done     (fetch_done),
    .fetch_external (fetch_external)
);

// File: tb/ext_bus_sequencer_test.sv
module ext_bus_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_code_n = 1'b0;
    logic [7:0]  hi_port_reg = 8'h00;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_ack, fetch_done, fetch_external;
    logic [7:0]  code_byte;
    logic        data_req = 1'b0;
    logic        data_write = 1'b0;
    logic        data_wide = 1'b0;
    logic [15:0] data_addr = '0;
    logic [7:0]  data_wbyte = '0;
    logic        data_ack, data_done;
    logic [7:0]  data_rbyte;
    logic        ale, psen_n, rd_n, wr_n;
    logic [7:0]  lo_out;
    logic        lo_oe;
    logic [7:0]  lo_in = 8'hFF;
    logic [7:0]  hi_out;
    logic        hi_strong;

    int vec = 0;
    int bad = 0;
    int n_data = 0;
    int long_gaps = 0;
    int gap = 0;
    int ale_hi = 0;
    bit seen = 0;
    bit ale_prev = 0;
    bit next_first = 1;
    bit finished = 0;

    always #4 clk = ~clk;

    ext_bus_sequencer uut (
        .clk(clk), .rst_n(rst_n), .ext_code_n(ext_code_n), .hi_port_reg(hi_port_reg),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
        .fetch_done(fetch_done), .fetch_external(fetch_external), .code_byte(code_byte),
        .data_req(data_req), .data_write(data_write), .data_wide(data_wide),
        .data_addr(data_addr), .data_wbyte(data_wbyte), .data_ack(data_ack),
        .data_done(data_done), .data_rbyte(data_rbyte), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in),
        .hi_out(hi_out), .hi_strong(hi_strong)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R1 / R2: strobe spacing monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (ale && !ale_prev) begin
                if (seen) begin
                    vec++;
                    if (gap != 6 && gap != 12) begin
                        bad++;
                        $display("FAIL R1 ale spacing actual=%0d expected=6 or 12", gap);
                    end
                    if (gap == 12) long_gaps++;
                end
                seen = 1;
                gap = 1;
            end else begin
                gap++;
            end
            ale_prev = ale;
        end
    end

    // Kinds: 0 idle, 1 internal code, 2 external code, 3 data address, 4 data transfer
    task automatic do_half(input int k, input logic we, input logic wide,
                           input logic [15:0] a, input logic [7:0] wd, input logic [7:0] rb);
        for (int s = 0; s < 6; s++) begin
            logic e_ale, e_psen, e_rd, e_wr, adrv, wdrv, hdrv;
            logic [7:0] e_lo;
            string lo_tag, hi_tag;
            @(negedge clk);
            e_ale  = (s < 2) && (k != 4);
            e_psen = !(k == 2 && s >= 2 && s <= 4);
            e_rd   = !(k == 4 && !we && s >= 1 && s <= 4);
            e_wr   = !(k == 4 && we && s >= 1 && s <= 4);
            adrv   = (k == 2 || k == 3) && s < 2;
            wdrv   = we && (k == 3 || k == 4) && !adrv;
            e_lo   = adrv ? a[7:0] : (wdrv ? wd : 8'hFF);
            hdrv   = (k == 2) || ((k == 3 || k == 4) && wide);
            lo_tag = (k == 0 || k == 1) ? "R11 low port idle" : "R3 low port";
            hi_tag = hdrv ? "R5 high port address" : "R6 high port register";
            if (ale) ale_hi++;
            chk("R1 ale", ale, e_ale);
            chk("R8 psen_n", psen_n, e_psen);
            chk("R9 rd_n", rd_n, e_rd);
            chk("R9 wr_n", wr_n, e_wr);
            chk(lo_tag, lo_oe, adrv || wdrv);
            chk(lo_tag, lo_out, e_lo);
            chk(hi_tag, hi_out, hdrv ? a[15:8] : hi_port_reg);
            chk(hi_tag, hi_strong, hdrv);
            chk("R10 fetch_ack", fetch_ack, (k == 1 || k == 2) && s == 0);
            chk("R10 data_ack", data_ack, k == 3 && s == 0);
            chk("R8 fetch_done", fetch_done, (k == 1 || k == 2) && s == 5);
            chk("R4 data_done", data_done, k == 4 && s == 5);
            if (k == 1 || k == 2) chk("R7 fetch_external", fetch_external, k == 2);
            if (s == 0) begin
                if (k == 3) data_req = 1'b0;
                if (k == 1 || k == 2) fetch_req = 1'b0;
            end
            if (s == 5) begin
                if (k == 2) chk("R8 code byte", code_byte, rb);
                if (k == 4 && !we) chk("R4 read byte", data_rbyte, rb);
            end
            lo_in = (s == 4) ? rb : ~rb;
        end
        next_first = !next_first;
    endtask

    task automatic fetch_slot(input logic ea, input logic [15:0] a, input logic [7:0] rb);
        ext_code_n = ea;
        fetch_req  = 1'b1;
        fetch_addr = a;
        do_half((!ea || a >= 16'h1000) ? 2 : 1, 1'b0, 1'b0, a, 8'h00, rb);
    endtask

    task automatic data_access(input logic we, input logic wide, input logic [15:0] a,
                               input logic [7:0] wd, input logic [7:0] rb);
        data_req   = 1'b1;
        data_write = we;
        data_wide  = wide;
        data_addr  = a;
        data_wbyte = wd;
        if (!next_first) do_half(0, 1'b0, 1'b0, a, 8'h00, 8'hFF); // R10 waits a half
        ale_hi = 0;
        do_half(3, we, wide, a, wd, rb);
        do_half(4, we, wide, a, wd, rb);
        chk("R2 one pulse per data cycle", 16'(ale_hi), 16'd2);
        n_data++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] fadr [6];
        logic [15:0] dadr [4];
        fadr = '{16'h0000, 16'h0001, 16'h0FFF, 16'h1000, 16'h5A3C, 16'hFFFF};
        dadr = '{16'h0000, 16'h00FF, 16'h7F80, 16'hFFFF};
        // R11: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R11 reset ale", ale, 1'b0);
            chk("R11 reset psen_n", psen_n, 1'b1);
            chk("R11 reset rd_n", rd_n, 1'b1);
            chk("R11 reset wr_n", wr_n, 1'b1);
            chk("R11 reset lo_oe", lo_oe, 1'b0);
            chk("R11 reset lo_out", lo_out, 8'hFF);
            chk("R11 reset hi_strong", hi_strong, 1'b0);
        end
        hi_port_reg = 8'hC3;
        rst_n = 1'b1;
        do_half(0, 1'b0, 1'b0, 16'h0, 8'h0, 8'hFF);
        do_half(0, 1'b0, 1'b0, 16'h0, 8'h0, 8'hFF);
        // R7 / R8: fetch sweep over pin level and limit boundary
        for (int e = 0; e < 2; e++)
            for (int i = 0; i < 6; i++)
                fetch_slot(e[0], fadr[i], fadr[i][7:0] ^ 8'h5A);
        // R3 R4 R5 R6 R9 R10: data sweep, alternating alignment
        for (int w = 0; w < 2; w++)
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < 4; i++) begin
                    hi_port_reg = 8'(8'h11 * (i + 1) + w * 8'h40 + d);
                    if (i[0]) fetch_slot(1'b1, 16'h0100 + 16'(i), 8'h00);
                    data_access(w[0], d[0], dadr[i], dadr[i][15:8] ^ 8'hA5,
                                dadr[i][7:0] ^ 8'h3C);
                end
        // R10: simultaneous requests, data goes first, fetch follows
        if (!next_first) do_half(0, 1'b0, 1'b0, 16'h0, 8'h0, 8'hFF);
        ext_code_n = 1'b0;
        fetch_req  = 1'b1;
        fetch_addr = 16'h2345;
        data_access(1'b0, 1'b1, 16'hBEEF, 8'h00, 8'h96);
        fetch_slot(1'b0, 16'h2345, 8'h69);
        do_half(0, 1'b0, 1'b0, 16'h0, 8'h0, 8'hFF);
        do_half(0, 1'b0, 1'b0, 16'h0, 8'h0, 8'hFF);
        @(negedge clk);
        chk("R2 skipped pulses equal data accesses", 16'(long_gaps), 16'(n_data));
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule